// File: doc/BRIEF.md
# H-Bridge PWM Gate Generator

This block drives the four switches of a single-phase H-bridge from one duty value. A free-running counter advances once per prescaled tick and is compared with a latched duty value. The comparison result, registered, is the gate signal shared by the first diagonal switch pair. The block does not derive the gate of the second diagonal pair by inverting the first. A one-shot starts on every falling edge of the first pair's signal. It first holds low for a gap that shrinks as the duty grows, then drives a pulse as long as the duty. The dead time between the two pairs therefore follows from the duty value.

The duty input is one bit wider than the counter, so both 0% and 100% are reachable. A new duty value takes effect only when the counter wraps, so a period never mixes two duty values. For the second pair, the duty is clamped to a half-scale limit so that the gap cannot underflow. A hard interlock keeps the two pairs from ever being on together. A synchronous active-high reset turns every gate off.

Top module: `hbridge_pwm_gates`

## Requirements
- R1: While `rst` is high, both gate outputs are low on the following clock edge. After reset the counter is 0 and the latched duty is 0.
- R2: The counter advances by one on each clock edge where `tick` is high and holds when `tick` is low. It wraps from 2^CNT_W-1 to 0, so one period lasts 2^CNT_W ticks.
- R3: `gate_a` is high exactly when the counter value is less than the latched duty. It reflects the counter one clock after each counter change. A latched duty of 2^CNT_W keeps it high for the whole period.
- R4: `duty` is sampled only on the tick that wraps the counter from 2^CNT_W-1 to 0. A change at any other time has no effect until that wrap.
- R5: Let H = 2^(CNT_W-1)-1 and m = min(latched duty, H). After a falling edge of the first-pair signal, `gate_b` stays low for H-m ticks. With CNT_W=8, H is 127 and `gate_b` rises when the counter reaches max(duty, 127).
- R6: After the gap of R5, `gate_b` stays high for m ticks. It covers counter values max(d,127) through max(d,127)+m-1. The pulse runs on into the next period only when that period's duty is 0.
- R7: No pulse appears on `gate_b` when the latched duty is 0 or 2^CNT_W. A falling edge that coincides with a clamped width of 0 starts no pulse.
- R8: `gate_a` and `gate_b` are never high in the same cycle. While the first-pair comparison is high, any pending or active one-shot is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable, one clock wide |
| duty | input | CNT_W+1 | Requested duty in ticks, 0 to 2^CNT_W |
| gate_a | output | 1 | Gate for the first diagonal pair (g1/g2) |
| gate_b | output | 1 | Gate for the second diagonal pair (g3/g4) |

## Verification
The bench steps through a list of duty values that runs in one pass: the two extremes, values just below, at and just above the half-scale clamp, and a spread of values in between. It compares both gates with arithmetic expectations at every counter value. Sequences such as full duty followed by zero, or high duty followed by zero, tell apart a pulse that is correctly cancelled at the next period's rise from one that carries over into an empty period. Each new duty is applied mid-period, which separates latching at wrap from immediate use. A reset issued during an active pulse and a long stall of `tick` isolate the reset and hold behaviour.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // States of the second-pair one-shot
  typedef enum logic [1:0] {
    OS_IDLE = 2'd0,
    OS_GAP  = 2'd1,
    OS_HIGH = 2'd2
  } os_state_t;

endpackage

// File: rtl/hbg_counter.sv
module hbg_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W:0]   duty_in,
  output logic [CNT_W:0]   duty_q,
  output logic             pwm_now,
  output logic             pwm_q
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap    = tick && (cnt == '1);
  assign pwm_now = ({1'b0, cnt} < duty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      if (wrap) duty_q <= duty_in;
      pwm_q <= pwm_now;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '1) |=> (cnt == '0)); // R2
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(tick && cnt == '1) |=> $stable(duty_q)); // R4

endmodule

// File: rtl/hbg_oneshot.sv
module hbg_oneshot
  import hbg_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         pwm_now,
  input  logic         pwm_q,
  input  logic [W-1:0] width,
  output logic         pulse_q
);

  localparam logic [W-1:0] FULL = '1;

  os_state_t    st, nst;
  logic [W-1:0] rem, nrem;
  logic [W-1:0] wid_q, nwid;

  always_comb begin
    nst  = st;
    nrem = rem;
    nwid = wid_q;
    if (pwm_now) begin
      nst  = OS_IDLE;
      nrem = '0;
    end else if (pwm_q) begin
      nwid = width;
      if (width == '0) begin
        nst  = OS_IDLE;
        nrem = '0;
      end else if (width == FULL) begin
        nst  = OS_HIGH;
        nrem = width;
      end else begin
        nst  = OS_GAP;
        nrem = FULL - width;
      end
    end else if (tick) begin
      case (st)
        OS_GAP: begin
          if (rem == W'(1)) begin
            nst  = OS_HIGH;
            nrem = wid_q;
          end else begin
            nrem = rem - 1'b1;
          end
        end
        OS_HIGH: begin
          if (rem == W'(1)) begin
            nst  = OS_IDLE;
            nrem = '0;
          end else begin
            nrem = rem - 1'b1;
          end
        end
        default: begin
          nst  = OS_IDLE;
          nrem = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= OS_IDLE;
      rem     <= '0;
      wid_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st      <= nst;
      rem     <= nrem;
      wid_q   <= nwid;
      pulse_q <= (nst == OS_HIGH);
    end
  end

  AST_ABORT_ON_A: assert property (@(posedge clk) disable iff (rst)
    pwm_now |=> !pulse_q); // R8
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (pwm_q && !pwm_now && width == '0) |=> !pulse_q); // R7
  AST_REM_LIVE: assert property (@(posedge clk) disable iff (rst)
    (st != OS_IDLE) |-> (rem != '0)); // R5
  AST_RISE_A_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> !pwm_q); // R8

endmodule

// File: rtl/hbridge_pwm_gates.sv
module hbridge_pwm_gates #(
  parameter int CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [CNT_W:0] duty,
  output logic           gate_a,
  output logic           gate_b
);

  localparam int            HW     = CNT_W - 1;
  localparam logic [HW-1:0] HALF_V = '1;

  logic [CNT_W:0] duty_q;
  logic           pwm_now;
  logic           pwm_q;
  logic [HW-1:0]  width_c;
  logic           pulse_q;

  hbg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .duty_in (duty),
    .duty_q  (duty_q),
    .pwm_now (pwm_now),
    .pwm_q   (pwm_q)
  );

  // Clamp the duty to half scale so the gap never underflows
  always_comb begin
    if (duty_q > {2'b00, HALF_V}) width_c = HALF_V;
    else                          width_c = duty_q[HW-1:0];
  end

  hbg_oneshot #(.W(HW)) u_os (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pwm_now (pwm_now),
    .pwm_q   (pwm_q),
    .width   (width_c),
    .pulse_q (pulse_q)
  );

  assign gate_a = pwm_q;
  assign gate_b = pulse_q;

  AST_GATE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(gate_a && gate_b)); // R8
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (!gate_a && !gate_b)); // R1

endmodule

// File: tb/tb_hbridge_pwm_gates.sv
module tb_hbridge_pwm_gates;

  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int NDL   = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [CW:0] duty = '0;
  logic        gate_a, gate_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int bcnt = 0;
  int cur_d = 0;
  int prev_d = 0;
  int dl [NDL];

  hbridge_pwm_gates #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .tick(tick), .duty(duty),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit in_win(int x, int d);
    int m, s;
    if (d < 1 || d > 255) return 1'b0;
    m = (d < 127) ? d : 127;
    s = (d < 127) ? 127 : d;
    return (x >= s) && (x <= s + m - 1);
  endfunction

  function automatic bit exp_b(int c, int d, int p);
    return in_win(c, d) || (d == 0 && in_win(c + 256, p));
  endfunction

  task automatic chk(string req, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (cnt %0d duty %0d prev %0d)",
               req, act, expv, bcnt, cur_d, prev_d);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    bcnt = (bcnt + 1) % 256;
    if (bcnt == 0) begin
      prev_d = cur_d;
      cur_d  = int'(duty);
    end
  endtask

  task automatic check_now();
    bit eb;
    chk((cur_d != prev_d) ? "R4" : "R3", gate_a, (bcnt < cur_d));
    eb = exp_b(bcnt, cur_d, prev_d);
    if (eb)                            chk("R6", gate_b, 1'b1);
    else if (cur_d == 0 || cur_d == 256) chk("R7", gate_b, 1'b0);
    else                               chk("R5", gate_b, 1'b0);
    chk("R8", !(gate_a && gate_b), 1'b1);
  endtask

  initial begin
    dl[0] = 256; dl[1] = 0;   dl[2] = 255; dl[3] = 0;
    dl[4] = 128; dl[5] = 0;   dl[6] = 127; dl[7] = 129;
    dl[8] = 1;   dl[9] = 126; dl[10] = 254; dl[11] = 256;
    for (int i = 12; i < NDL; i++) dl[i] = (i * 37) % 257;

    repeat (3) @(negedge clk);
    chk("R1", gate_a, 1'b0);
    chk("R1", gate_b, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", gate_a, 1'b0);

    // Duty sweep: each value applied mid-period, active from the next wrap
    for (int k = 0; k < NDL; k++) begin
      for (int t = 0; t < 256; t++) begin
        if (t == 100) duty = (CW+1)'(dl[k]);
        do_tick();
        check_now();
      end
    end
    // One more period so the last value is observed
    for (int t = 0; t < 256; t++) begin
      if (t == 100) duty = 9'd200;
      do_tick();
      check_now();
    end

    // Reset during an active second-pair pulse
    while (bcnt != 210) begin
      do_tick();
      check_now();
    end
    chk("R6", gate_b, 1'b1);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk("R1", gate_a, 1'b0);
    chk("R1", gate_b, 1'b0);
    rst = 1'b0;
    bcnt = 0; cur_d = 0; prev_d = 0;
    duty = 9'd50;
    for (int t = 0; t < 20; t++) begin
      do_tick();
      check_now();
    end

    // Stall tick with gate_a high, then resume
    while (!(cur_d == 50 && bcnt == 49)) begin
      do_tick();
      check_now();
    end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R2", gate_a, 1'b1);
      chk("R2", gate_b, 1'b0);
    end
    do_tick();
    chk("R3", gate_a, 1'b0);
    chk("R2", gate_a, (bcnt < cur_d));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule